// File: doc/BRIEF.md
# SDRAM Refresh and Clock-Enable Power Sequencer

This block sits on the controller side of an SDRAM interface. It issues periodic auto-refresh commands and controls the clock-enable (CKE) line that moves the memory between its low-power states. An interval timer divides the refresh window into one slot per row. Each slot adds one refresh to a backlog. While the backlog is non-zero, the block asks the command arbiter to close every bank. Once the arbiter reports that all banks are precharged, the block issues the owed refreshes back to back, each one followed by the refresh recovery time.

A requester can ask for one of three low-power states. Each state is entered by dropping CKE in the same cycle as a specific command: a no-op for power-down, an auto refresh for self-refresh, and a burst terminate for deep power-down. Power-down is left on a wake request, or automatically as soon as a refresh falls due, so that time spent in power-down never exceeds one refresh slot. Self-refresh needs no refreshes from the controller, so the backlog and the interval are restarted when it is entered. Deep power-down is left only through reset, because the memory then needs a full re-initialisation. After CKE rises, the block sends only no-ops for a fixed exit delay.

Top module: `refresh_power_seq`

## Requirements
- R1: While rst_ni is low, and at the first sample after reset, cke_o is 1, cmd_o is 0 (NOP), state_o is 0 (RUN) and close_req_o is 0.
- R2: In every state except self-refresh (3) and deep power-down (4), one refresh falls due every INT_CYC = T_REF_CYC/N_ROWS cycles. While the block is in RUN and a refresh is owed, close_req_o is 1; otherwise it is 0. With the banks always idle, any window of 10*INT_CYC cycles contains exactly 10 refresh commands.
- R3: cmd_o encodes 0 = NOP, 1 = REF (auto refresh), 2 = BST (burst terminate). A REF is issued from RUN only in the cycle after all_idle_i was sampled high. Owed refreshes follow one another exactly T_RFC cycles apart, with NOPs in between.
- R4: The backlog saturates at MAX_PEND; refreshes that fall due while it is full are dropped.
- R5: When mode_req_i is 1 (power-down), no refresh is owed and all_idle_i is high, cke_o goes low with a NOP and state_o becomes 2. An owed refresh is issued before power-down is entered.
- R6: From power-down, either wake_i or a refresh falling due raises cke_o; from self-refresh, only wake_i does. cke_o rises with state_o = 5 (EXIT), and cmd_o stays NOP for T_XP cycles starting with the cycle in which cke_o rises. wake_i has no effect in RUN.
- R7: When mode_req_i is 2 (self-refresh), entry is a REF with cke_o low, and state_o becomes 3. No REF is issued while in self-refresh. The backlog is cleared on entry, and the interval restarts from zero after wake.
- R8: When mode_req_i is 3 (deep power-down), entry is a BST with cke_o low, and state_o becomes 4. The block stays in this state, ignoring wake_i and mode_req_i, until reset.
- R9: state_o encodes 0 = RUN, 1 = refresh recovery wait, 2 = power-down, 3 = self-refresh, 4 = deep power-down, 5 = exit delay. It follows the transitions above cycle by cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| all_idle_i | input | 1 | All banks precharged, from the command arbiter |
| mode_req_i | input | 2 | Low-power request: 0 none, 1 power-down, 2 self-refresh, 3 deep power-down |
| wake_i | input | 1 | Request to leave power-down or self-refresh |
| cmd_o | output | 2 | Command to the memory: 0 NOP, 1 REF, 2 BST |
| cke_o | output | 1 | Clock enable to the memory |
| close_req_o | output | 1 | Request to the arbiter to precharge all banks |
| state_o | output | 3 | Sequencer state code |

## Verification
The hardest case to reach is a full backlog draining while new refresh slots keep arriving. The expected number of refresh commands then depends on where the interval timer stands. The bench holds all_idle_i low for several intervals so that the backlog saturates, then releases it. It compares the refresh count against a behavioural model that tracks every slot, and it checks the spacing of the first eight commands. A second hard case is the automatic exit from power-down when a refresh falls due, with no wake request. The bench keeps the power-down request asserted, so the block falls back into power-down after each forced exit, and it checks the exit delay and the refresh that follows.

// File: rtl/rps_pkg.sv
package rps_pkg;
  typedef enum logic [1:0] {CMD_NOP = 2'd0, CMD_REF = 2'd1, CMD_BST = 2'd2} cmd_e;
  typedef enum logic [1:0] {REQ_NONE = 2'd0, REQ_PD = 2'd1, REQ_SR = 2'd2, REQ_DPD = 2'd3} req_e;
  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_RFC  = 3'd1,
    ST_PD   = 3'd2,
    ST_SR   = 3'd3,
    ST_DPD  = 3'd4,
    ST_EXIT = 3'd5
  } st_e;
endpackage

// File: rtl/rps_interval_timer.sv
module rps_interval_timer #(
  parameter int INT_CYC = 781
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int W = (INT_CYC < 2) ? 1 : $clog2(INT_CYC);
  localparam logic [W-1:0] LAST = W'(INT_CYC - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = en_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (en_i)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_clr_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/rps_pend_ctr.sv
module rps_pend_ctr #(
  parameter int MAX_PEND = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  input  logic clr_i,
  output logic nz_o
);
  localparam int PW = $clog2(MAX_PEND + 1);
  localparam logic [PW-1:0] TOP = PW'(MAX_PEND);

  logic [PW-1:0] pend_q, pend_d, after_dec;

  always_comb begin
    after_dec = pend_q - PW'(dec_i);
    pend_d    = after_dec;
    if (inc_i && after_dec < TOP) pend_d = after_dec + 1'b1;
    if (clr_i) pend_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign nz_o = (pend_q != '0);

  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= TOP);
  p_no_underflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> (pend_q != '0));
  p_full_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == TOP && inc_i && !dec_i && !clr_i) |=> (pend_q == TOP));
endmodule

// File: rtl/refresh_power_seq.sv
module refresh_power_seq
  import rps_pkg::*;
#(
  parameter int T_REF_CYC = 6400000,
  parameter int N_ROWS    = 8192,
  parameter int T_RFC     = 8,
  parameter int T_XP      = 4,
  parameter int MAX_PEND  = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       all_idle_i,
  input  logic [1:0] mode_req_i,
  input  logic       wake_i,
  output logic [1:0] cmd_o,
  output logic       cke_o,
  output logic       close_req_o,
  output logic [2:0] state_o
);
  localparam int INT_CYC = T_REF_CYC / N_ROWS;
  localparam int MAXT    = (T_RFC > T_XP) ? T_RFC : T_XP;
  localparam int WW      = $clog2(MAXT + 1);

  st_e           state_q, state_d;
  cmd_e          cmd_q, cmd_d;
  logic          cke_q, cke_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          tick, pend_nz, ref_go, sr_go, tmr_en;
  req_e          req;

  assign req    = req_e'(mode_req_i);
  assign tmr_en = (state_q != ST_SR) && (state_q != ST_DPD);

  rps_interval_timer #(.INT_CYC(INT_CYC)) u_tmr (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(tmr_en), .clr_i(sr_go), .tick_o(tick)
  );

  rps_pend_ctr #(.MAX_PEND(MAX_PEND)) u_pend (
    .clk_i (clk_i), .rst_ni(rst_ni), .inc_i(tick), .dec_i(ref_go), .clr_i(sr_go),
    .nz_o  (pend_nz)
  );

  always_comb begin
    state_d = state_q;
    cmd_d   = CMD_NOP;
    cke_d   = cke_q;
    wcnt_d  = wcnt_q;
    ref_go  = 1'b0;
    sr_go   = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (pend_nz && all_idle_i) begin
          // owed refresh wins over any power request
          ref_go  = 1'b1;
          cmd_d   = CMD_REF;
          state_d = ST_RFC;
          wcnt_d  = WW'(T_RFC - 2);
        end else if (!pend_nz && all_idle_i) begin
          unique case (req)
            REQ_PD:  begin state_d = ST_PD;  cke_d = 1'b0; end
            REQ_SR:  begin state_d = ST_SR;  cke_d = 1'b0; cmd_d = CMD_REF; sr_go = 1'b1; end
            REQ_DPD: begin state_d = ST_DPD; cke_d = 1'b0; cmd_d = CMD_BST; end
            default: ;
          endcase
        end
      end
      ST_RFC, ST_EXIT: begin
        if (wcnt_q == '0) state_d = ST_RUN;
        else              wcnt_d  = wcnt_q - 1'b1;
      end
      ST_PD: begin
        // refresh due bounds the power-down time
        if (pend_nz || wake_i) begin
          state_d = ST_EXIT; cke_d = 1'b1; wcnt_d = WW'(T_XP - 2);
        end
      end
      ST_SR: begin
        if (wake_i) begin
          state_d = ST_EXIT; cke_d = 1'b1; wcnt_d = WW'(T_XP - 2);
        end
      end
      ST_DPD: ;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      cmd_q   <= CMD_NOP;
      cke_q   <= 1'b1;
      wcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      cke_q   <= cke_d;
      wcnt_q  <= wcnt_d;
    end
  end

  assign cmd_o       = cmd_q;
  assign cke_o       = cke_q;
  assign state_o     = state_q;
  assign close_req_o = (state_q == ST_RUN) && pend_nz;

  p_ref_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF) |-> $past(all_idle_i));
  p_ref_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF) |=> (cmd_o == CMD_NOP));
  p_pd_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PD) |-> (!cke_o && cmd_o == CMD_NOP));
  p_exit_nop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXIT) |-> (cke_o && cmd_o == CMD_NOP));
  p_sr_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SR && $past(state_q) != ST_SR) |-> (cmd_o == CMD_REF && !cke_o));
  p_dpd_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DPD) |=> (state_q == ST_DPD && !cke_o));
endmodule

// File: tb/sim_refresh_power_seq.sv
module sim_refresh_power_seq;
  localparam int T_REF_CYC = 256;
  localparam int N_ROWS    = 8;
  localparam int INT_CYC   = T_REF_CYC / N_ROWS;
  localparam int T_RFC     = 4;
  localparam int T_XP      = 3;
  localparam int MAX_PEND  = 8;
  localparam int S_RUN = 0, S_RFC = 1, S_PD = 2, S_SR = 3, S_DPD = 4, S_EXIT = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       all_idle = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       wake = 1'b0;
  logic [1:0] cmd_o;
  logic       cke_o, close_req_o;
  logic [2:0] state_o;

  refresh_power_seq #(
    .T_REF_CYC(T_REF_CYC), .N_ROWS(N_ROWS), .T_RFC(T_RFC), .T_XP(T_XP), .MAX_PEND(MAX_PEND)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .all_idle_i(all_idle), .mode_req_i(mode), .wake_i(wake),
    .cmd_o(cmd_o), .cke_o(cke_o), .close_req_o(close_req_o), .state_o(state_o)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // behavioural reference model
  int m_st = 0, m_cmd = 0, m_cke = 1, m_w = 0, m_pend = 0, m_t = 0, m_ticks = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = S_RUN; m_cmd = 0; m_cke = 1; m_w = 0; m_pend = 0; m_t = 0;
    end else begin
      int nst, ncmd, ncke, nw, p;
      bit rgo, srgo, tk, en;
      nst = m_st; ncmd = 0; ncke = m_cke; nw = m_w; rgo = 0; srgo = 0;
      en = (m_st != S_SR) && (m_st != S_DPD);
      tk = en && (m_t == INT_CYC - 1);
      case (m_st)
        S_RUN: begin
          if (m_pend > 0 && all_idle) begin
            ncmd = 1; rgo = 1; nst = S_RFC; nw = T_RFC - 2;
          end else if (m_pend == 0 && all_idle) begin
            if (mode == 2'd1) begin nst = S_PD; ncke = 0; end
            else if (mode == 2'd2) begin nst = S_SR; ncke = 0; ncmd = 1; srgo = 1; end
            else if (mode == 2'd3) begin nst = S_DPD; ncke = 0; ncmd = 2; end
          end
        end
        S_RFC, S_EXIT: if (m_w == 0) nst = S_RUN; else nw = m_w - 1;
        S_PD: if (m_pend > 0 || wake) begin nst = S_EXIT; ncke = 1; nw = T_XP - 2; end
        S_SR: if (wake) begin nst = S_EXIT; ncke = 1; nw = T_XP - 2; end
        default: ;
      endcase
      if (srgo) begin
        m_t = 0; m_pend = 0;
      end else begin
        if (en) m_t = (m_t == INT_CYC - 1) ? 0 : m_t + 1;
        p = m_pend - (rgo ? 1 : 0);
        if (tk) begin
          m_ticks++;
          if (p < MAX_PEND) p++;
        end
        m_pend = p;
      end
      m_st = nst; m_cmd = ncmd; m_cke = ncke; m_w = nw;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 model cmd", int'(cmd_o), m_cmd);
      chk("R5 model cke", int'(cke_o), m_cke);
      chk("R9 model state", int'(state_o), m_st);
      chk("R2 model close_req", int'(close_req_o), (m_st == S_RUN && m_pend > 0) ? 1 : 0);
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_cke(input logic v, input string tag);
    int k = 0;
    while (cke_o !== v && k < 200) begin step(); k++; end
    chk(tag, int'(cke_o), int'(v));
  endtask

  task automatic wait_no_backlog();
    int k = 0;
    while (close_req_o !== 1'b0 && k < 200) begin step(); k++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired, actual=running expected=finished");
      report();
    end
  end

  initial begin
    int n, t0, t1, last;
    repeat (3) step();
    chk("R1 reset cke", int'(cke_o), 1);
    chk("R1 reset cmd", int'(cmd_o), 0);
    chk("R1 reset state", int'(state_o), 0);
    chk("R1 reset close_req", int'(close_req_o), 0);
    rst_n = 1'b1;
    step();
    chk("R1 first sample cke", int'(cke_o), 1);

    // R2: periodic refresh with idle banks
    all_idle = 1'b1;
    repeat (5) step();
    n = 0;
    repeat (10 * INT_CYC) begin step(); if (cmd_o == 2'd1) n++; end
    chk("R2 refreshes in ten intervals", n, 10);

    // R3/R4: stall then drain a saturated backlog
    all_idle = 1'b0;
    n = 0;
    repeat (13 * INT_CYC) begin step(); if (cmd_o == 2'd1) n++; end
    chk("R3 no refresh while busy", n, 0);
    chk("R2 close_req with backlog", int'(close_req_o), 1);
    t0 = m_ticks; t1 = t0; n = 0; last = 0;
    all_idle = 1'b1;
    for (int i = 1; i <= 100; i++) begin
      step();
      if (i == 99) t1 = m_ticks;
      if (cmd_o == 2'd1) begin
        if (n > 0 && n < 8) chk("R3 back-to-back spacing", i - last, T_RFC);
        if (n == 0) chk("R3 first owed refresh latency", i, 1);
        last = i; n++;
      end
    end
    chk("R4 saturated backlog count", n, MAX_PEND + (t1 - t0));

    // R5/R6: power-down, forced exit by due refresh
    wait_no_backlog();
    mode = 2'd1;
    wait_cke(1'b0, "R5 power-down entry cke");
    chk("R5 entry command NOP", int'(cmd_o), 0);
    chk("R5 state power-down", int'(state_o), S_PD);
    wait_cke(1'b1, "R6 exit on refresh due");
    chk("R6 exit state", int'(state_o), S_EXIT);
    chk("R6 exit first NOP", int'(cmd_o), 0);
    for (int j = 1; j < T_XP; j++) begin
      step();
      chk("R6 exit delay NOP", int'(cmd_o), 0);
      chk("R6 exit delay cke", int'(cke_o), 1);
    end
    step();
    chk("R6 refresh after exit delay", int'(cmd_o), 1);

    // R6: wake from power-down
    wait_cke(1'b0, "R5 power-down re-entry");
    mode = 2'd0; wake = 1'b1;
    step();
    wake = 1'b0;
    chk("R6 wake raises cke", int'(cke_o), 1);

    // R5: owed refresh before power-down
    all_idle = 1'b0;
    repeat (INT_CYC + 8) step();
    mode = 2'd1; all_idle = 1'b1;
    step();
    chk("R5 refresh has priority", int'(cmd_o), 1);
    chk("R5 cke high on priority refresh", int'(cke_o), 1);
    mode = 2'd0;
    repeat (20) step();

    // R6: wake ignored in RUN
    wake = 1'b1;
    n = 0;
    repeat (5) begin step(); if (cke_o != 1'b1 || state_o == 3'(S_EXIT)) n++; end
    wake = 1'b0;
    chk("R6 wake ignored in RUN", n, 0);

    // R7: self-refresh
    wait_no_backlog();
    mode = 2'd2;
    wait_cke(1'b0, "R7 self-refresh entry cke");
    chk("R7 entry command REF", int'(cmd_o), 1);
    chk("R7 state self-refresh", int'(state_o), S_SR);
    mode = 2'd0;
    n = 0;
    repeat (6 * INT_CYC) begin step(); if (cmd_o != 2'd0 || cke_o != 1'b0) n++; end
    chk("R7 quiet in self-refresh", n, 0);
    wake = 1'b1;
    step();
    wake = 1'b0;
    chk("R6 wake leaves self-refresh", int'(cke_o), 1);
    chk("R7 backlog cleared", int'(close_req_o), 0);
    n = 0;
    repeat (INT_CYC - 4) begin step(); if (cmd_o == 2'd1) n++; end
    chk("R7 interval restarted", n, 0);

    // R8: deep power-down
    wait_no_backlog();
    mode = 2'd3;
    wait_cke(1'b0, "R8 deep power-down entry cke");
    chk("R8 entry command BST", int'(cmd_o), 2);
    chk("R8 state deep power-down", int'(state_o), S_DPD);
    mode = 2'd0;
    n = 0;
    for (int i = 0; i < 4 * INT_CYC; i++) begin
      wake = i[0];
      mode = 2'(i);
      step();
      if (cke_o != 1'b0 || cmd_o != 2'd0 || state_o != 3'(S_DPD)) n++;
    end
    wake = 1'b0; mode = 2'd0;
    chk("R8 sticky until reset", n, 0);

    rst_n = 1'b0;
    step();
    chk("R1 reset leaves deep power-down cke", int'(cke_o), 1);
    chk("R1 reset state", int'(state_o), 0);
    rst_n = 1'b1;
    repeat (10) step();
    report();
  end
endmodule